// File: doc/BRIEF.md
# Three-Phase RGB Blink Engine

This block drives the three enables of one RGB LED from a small set of per-colour settings. Each colour has four 4-bit settings: brightness, ramp speed, ramp-on point and ramp-off point. A 2-bit blink-period code is shared by all three colours, and a handful of master controls complete the configuration. The block divides the system clock down to a microsecond-rate tick. From that tick it builds a PWM frame of three equal phases. In the normal mode red, green and blue each pulse only inside their own phase, so no two colours conduct at once. In the flash mode all three pulse together in every phase, which gives three times the average current for the same brightness code.

On top of the PWM frame a slower blink timebase splits each blink period into sixteen slots. A colour ramps its brightness up, one level at a time, when the slot counter enters its on-point. It ramps back down from its off-point. The pace of the ramp is set by its speed code. With the internal PWM switched off, each output simply follows a direct enable bit. An external PWM input can further gate any colour selected for it. Configuration arrives on parallel ports. It is sampled into a shadow copy while the block is stopped and at each frame boundary while it runs, so changes never cut a pulse short.

Top module: `rgb_blink_engine`

## Requirements
- R1: While `start` is 0 all three `led` bits are 0 and every counter is held at zero. When `start` returns to 1 the frame, blink and ramp state begin again from zero.
- R2: A frame is 3 phases of PHASE_TICKS ticks each, and a tick lasts TICK_DIV clocks. With internal PWM on and flash off, colour c (bit 0 red, bit 1 green, bit 2 blue) is driven only in phase c, in the order red, green, blue. It is high at phase position p exactly when p*15 < level*PHASE_TICKS.
- R3: With flash on, all three colours use the same rule in every phase, regardless of phase index.
- R4: A colour whose on-point and off-point are both 0 shows its duty code as its level at once, and its slope code has no effect.
- R5: A colour whose on-point equals its off-point and is not 0 stays dark.
- R6: The blink period is sixteen slots of SLOT_FRAMES<<cycle_sel frames each (cycle_sel 0..3 doubles the period per step). A colour targets its duty while the slot index s lies in [on, off). When on > off the window wraps round, so s >= on or s < off. Outside the window it targets 0.
- R7: At frame ends the level moves one step toward its target once every (2*slope+1)*STEP_FRAMES frames. It stops at the target, so it never overshoots the duty or falls below 0.
- R8: With internal PWM off, each `led` bit follows its `sw_en` bit steadily, with no phases, duty or blinking.
- R9: A colour whose `ext_en` bit is 1 is additionally ANDed with `ext_pwm` in either mode. Colours with `ext_en` 0 ignore `ext_pwm`.
- R10: While running, configuration inputs take effect only at the next frame end (every 3*PHASE_TICKS ticks).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Master run; 0 forces all outputs off |
| pwm_en | input | 1 | 1 = internal PWM, blink and ramp; 0 = direct enables |
| flash_en | input | 1 | 1 = all colours pulse together each phase |
| cycle_sel | input | 2 | Blink period code, shared by all colours |
| sw_en | input | 3 | Direct enables used when pwm_en is 0 |
| ext_en | input | 3 | Per-colour gating by ext_pwm |
| ext_pwm | input | 1 | External PWM gate |
| duty | input | 12 | Brightness codes, colour c in bits [4c+3:4c] |
| slope | input | 12 | Ramp speed codes, same packing |
| on_pt | input | 12 | Ramp-on slot, same packing |
| off_pt | input | 12 | Ramp-off slot, same packing |
| led | output | 3 | Output enables: bit 0 red, 1 green, 2 blue |

## Verification
The assertions assume that `start` is the only input that changes the run state. They also assume that configuration seen mid-frame is not relied on before the next frame end. The checks on the shadow copy and the ramp levels are valid only under that view. The stimulus meets this by holding `start` low while it changes the blink period and the mode bits. Inside a run it changes only the duty codes and the external gate. Random configurations keep the ramp speeds small and the blink periods short, so that several full blink cycles fit into every run.

// File: rtl/lbe_pkg.sv
package lbe_pkg;

  typedef struct packed {
    logic        pwm;
    logic        flash;
    logic [1:0]  cyc;
    logic [2:0]  sw;
    logic [2:0]  ext;
    logic [11:0] duty;
    logic [11:0] slope;
    logic [11:0] on_pt;
    logic [11:0] off_pt;
  } lbe_cfg_t;

  // High while the phase position lies inside the pulse for this level.
  function automatic logic pwm_hit(input int unsigned pos,
                                   input logic [3:0] lvl,
                                   input int unsigned phase_ticks);
    int unsigned l;
    l = {28'd0, lvl};
    return (pos * 15) < (l * phase_ticks);
  endfunction

  // Slot membership in the lit window, wrapping when on > off.
  function automatic logic in_window(input logic [3:0] s,
                                     input logic [3:0] on_p,
                                     input logic [3:0] off_p);
    if (on_p < off_p) return (s >= on_p) && (s < off_p);
    return (s >= on_p) || (s < off_p);
  endfunction

  // Level used when on and off points coincide: steady duty or dark.
  function automatic logic [3:0] pinned_level(input logic [3:0] on_p,
                                              input logic [3:0] duty_c);
    return (on_p == 4'd0) ? duty_c : 4'd0;
  endfunction

endpackage

// File: rtl/lbe_timebase.sv
module lbe_timebase #(
  parameter int TICK_DIV    = 100,
  parameter int PHASE_TICKS = 50,
  parameter int SLOT_FRAMES = 104,
  localparam int POS_W      = $clog2(PHASE_TICKS),
  localparam int SF_W       = $clog2(SLOT_FRAMES * 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       cyc,
  output logic             frame_end,
  output logic [POS_W-1:0] pos_q,
  output logic [1:0]       phase_q,
  output logic [3:0]       slot_q
);

  localparam logic [POS_W-1:0] POS_LAST = POS_W'(PHASE_TICKS - 1);

  logic tick;

  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int TD_W = $clog2(TICK_DIV);
      localparam logic [TD_W-1:0] TD_LAST = TD_W'(TICK_DIV - 1);
      logic [TD_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               div_q <= '0;
        else if (!run)            div_q <= '0;
        else if (div_q == TD_LAST) div_q <= '0;
        else                      div_q <= div_q + 1'b1;
      end
      assign tick = run && (div_q == TD_LAST);
    end else begin : g_nodiv
      assign tick = run;
    end
  endgenerate

  assign frame_end = tick && (pos_q == POS_LAST) && (phase_q == 2'd2);

  logic [SF_W:0]   slot_len;
  logic [SF_W-1:0] fc_q;
  logic            slot_wrap;

  assign slot_len  = (SF_W + 1)'(SLOT_FRAMES) << cyc;
  assign slot_wrap = ({1'b0, fc_q} == (slot_len - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      phase_q <= '0;
      fc_q    <= '0;
      slot_q  <= '0;
    end else if (!run) begin
      pos_q   <= '0;
      phase_q <= '0;
      fc_q    <= '0;
      slot_q  <= '0;
    end else begin
      if (tick) begin
        if (pos_q == POS_LAST) begin
          pos_q   <= '0;
          phase_q <= (phase_q == 2'd2) ? 2'd0 : phase_q + 2'd1;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
      if (frame_end) begin
        if (slot_wrap) begin
          fc_q   <= '0;
          slot_q <= slot_q + 4'd1;
        end else begin
          fc_q <= fc_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lbe_ramp.sv
module lbe_ramp
  import lbe_pkg::*;
#(
  parameter int STEP_FRAMES = 14,
  localparam int IV_W       = $clog2(31 * STEP_FRAMES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       frame_end,
  input  logic [3:0] slot,
  input  logic [3:0] duty_c,
  input  logic [3:0] slope_c,
  input  logic [3:0] on_c,
  input  logic [3:0] off_c,
  output logic [3:0] lvl_q
);

  logic [IV_W-1:0] cnt_q;
  logic [IV_W-1:0] limit;
  logic [3:0]      target;
  logic            pinned;

  assign limit  = IV_W'((2 * int'(slope_c) + 1) * STEP_FRAMES - 1);
  assign pinned = (on_c == off_c);
  assign target = in_window(slot, on_c, off_c) ? duty_c : 4'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      cnt_q <= '0;
    end else if (!run) begin
      lvl_q <= '0;
      cnt_q <= '0;
    end else if (frame_end) begin
      if (pinned) begin
        lvl_q <= pinned_level(on_c, duty_c);
        cnt_q <= '0;
      end else if (lvl_q == target) begin
        cnt_q <= '0;
      end else if (cnt_q >= limit) begin
        lvl_q <= (lvl_q < target) ? lvl_q + 4'd1 : lvl_q - 4'd1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lbe_phase_mux.sv
module lbe_phase_mux
  import lbe_pkg::*;
#(
  parameter int PHASE_TICKS = 50,
  parameter int POS_W       = 6
) (
  input  logic             start,
  input  logic             pwm_on,
  input  logic             flash_on,
  input  logic [2:0]       sw,
  input  logic [2:0]       ext_sel,
  input  logic             ext_pwm,
  input  logic [11:0]      lvl,
  input  logic [11:0]      duty,
  input  logic [11:0]      on_pt,
  input  logic [11:0]      off_pt,
  input  logic [POS_W-1:0] pos,
  input  logic [1:0]       phase,
  output logic [2:0]       led
);

  for (genvar c = 0; c < 3; c++) begin : g_col
    logic [3:0] eff;
    logic       active;
    logic       raw;
    logic       gate;

    assign eff    = (on_pt[4*c +: 4] == off_pt[4*c +: 4])
                    ? pinned_level(on_pt[4*c +: 4], duty[4*c +: 4])
                    : lvl[4*c +: 4];
    assign active = flash_on || (phase == 2'(c));
    assign raw    = pwm_on ? (active && pwm_hit(32'(pos), eff, PHASE_TICKS))
                           : sw[c];
    assign gate   = !ext_sel[c] || ext_pwm;
    assign led[c] = start && raw && gate;
  end

endmodule

// File: rtl/rgb_blink_engine.sv
module rgb_blink_engine
  import lbe_pkg::*;
#(
  parameter int TICK_DIV    = 100,
  parameter int PHASE_TICKS = 50,
  parameter int STEP_FRAMES = 14,
  parameter int SLOT_FRAMES = 104
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        pwm_en,
  input  logic        flash_en,
  input  logic [1:0]  cycle_sel,
  input  logic [2:0]  sw_en,
  input  logic [2:0]  ext_en,
  input  logic        ext_pwm,
  input  logic [11:0] duty,
  input  logic [11:0] slope,
  input  logic [11:0] on_pt,
  input  logic [11:0] off_pt,
  output logic [2:0]  led
);

  localparam int POS_W = $clog2(PHASE_TICKS);

  lbe_cfg_t         cfg_live;
  lbe_cfg_t         cfg_q;
  logic             frame_end;
  logic [POS_W-1:0] pos_q;
  logic [1:0]       phase_q;
  logic [3:0]       slot_q;
  logic [11:0]      lvl_all;

  assign cfg_live = '{pwm: pwm_en, flash: flash_en, cyc: cycle_sel,
                      sw: sw_en, ext: ext_en, duty: duty, slope: slope,
                      on_pt: on_pt, off_pt: off_pt};

  // Shadow copy: follows inputs while stopped, refreshes at frame ends.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cfg_q <= '0;
    else if (!start || frame_end) cfg_q <= cfg_live;
  end

  lbe_timebase #(
    .TICK_DIV(TICK_DIV), .PHASE_TICKS(PHASE_TICKS), .SLOT_FRAMES(SLOT_FRAMES)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .run(start), .cyc(cfg_q.cyc),
    .frame_end(frame_end), .pos_q(pos_q), .phase_q(phase_q), .slot_q(slot_q)
  );

  for (genvar c = 0; c < 3; c++) begin : g_ramp
    lbe_ramp #(.STEP_FRAMES(STEP_FRAMES)) u_ramp (
      .clk(clk), .rst_n(rst_n), .run(start), .frame_end(frame_end),
      .slot(slot_q),
      .duty_c(cfg_q.duty[4*c +: 4]), .slope_c(cfg_q.slope[4*c +: 4]),
      .on_c(cfg_q.on_pt[4*c +: 4]), .off_c(cfg_q.off_pt[4*c +: 4]),
      .lvl_q(lvl_all[4*c +: 4])
    );
  end

  lbe_phase_mux #(.PHASE_TICKS(PHASE_TICKS), .POS_W(POS_W)) u_mux (
    .start(start), .pwm_on(cfg_q.pwm), .flash_on(cfg_q.flash),
    .sw(cfg_q.sw), .ext_sel(cfg_q.ext), .ext_pwm(ext_pwm),
    .lvl(lvl_all), .duty(cfg_q.duty), .on_pt(cfg_q.on_pt),
    .off_pt(cfg_q.off_pt), .pos(pos_q), .phase(phase_q), .led(led)
  );

endmodule

// File: rtl/rgb_blink_engine_chk.sv
module rgb_blink_engine_chk #(
  parameter int POS_W   = 6,
  parameter int CFG_W   = 60
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [2:0]       led,
  input logic             frame_end,
  input logic [POS_W-1:0] pos_q,
  input logic [1:0]       phase_q,
  input logic [11:0]      lvl_all,
  input logic [CFG_W-1:0] cfg_bits,
  input logic             pwm_s,
  input logic             flash_s,
  input logic [11:0]      on_s,
  input logic [11:0]      off_s
);

  assert_restart_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) |-> (phase_q == 2'd0) && (pos_q == '0));

  assert_one_colour_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_s && !flash_s) |-> $onehot0(led));

  assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !frame_end) |=> $stable(lvl_all));

  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !frame_end) |=> $stable(cfg_bits));

  for (genvar c = 0; c < 3; c++) begin : g_dark
    assert_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_s && (on_s[4*c +: 4] == off_s[4*c +: 4]) && (on_s[4*c +: 4] != 4'd0))
      |-> !led[c]);
  end

endmodule

bind rgb_blink_engine rgb_blink_engine_chk #(
  .POS_W(POS_W), .CFG_W($bits(lbe_pkg::lbe_cfg_t))
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .led(led),
  .frame_end(frame_end), .pos_q(pos_q), .phase_q(phase_q),
  .lvl_all(lvl_all), .cfg_bits(cfg_q), .pwm_s(cfg_q.pwm),
  .flash_s(cfg_q.flash), .on_s(cfg_q.on_pt), .off_s(cfg_q.off_pt)
);

// File: tb/rgb_blink_engine_test.sv
module rgb_blink_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int TD  = 2;
  localparam int PH  = 6;
  localparam int SFS = 1;   // frames per ramp unit
  localparam int SLF = 2;   // frames per slot at cycle code 0
  localparam int FRAME_CLKS = TD * 3 * PH;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0, pwm_en = 0, flash_en = 0, ext_pwm = 0;
  logic [1:0]  cycle_sel = 0;
  logic [2:0]  sw_en = 0, ext_en = 0;
  logic [11:0] duty = 0, slope = 0, on_pt = 0, off_pt = 0;
  logic [2:0]  led;

  rgb_blink_engine #(.TICK_DIV(TD), .PHASE_TICKS(PH),
                     .STEP_FRAMES(SFS), .SLOT_FRAMES(SLF)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pwm_en(pwm_en),
    .flash_en(flash_en), .cycle_sel(cycle_sel), .sw_en(sw_en),
    .ext_en(ext_en), .ext_pwm(ext_pwm), .duty(duty), .slope(slope),
    .on_pt(on_pt), .off_pt(off_pt), .led(led));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;

  // reference state
  int e = 0, fdone = 0;
  int lv[3], cnt[3];
  logic        s_pwm, s_flash;
  logic [1:0]  s_cyc;
  logic [2:0]  s_sw, s_ext;
  logic [11:0] s_duty, s_slope, s_on, s_off;

  function automatic int nib(logic [11:0] v, int c);
    return int'(v[4*c +: 4]);
  endfunction

  function automatic bit lit_at(int s, int on_v, int off_v);
    if (on_v < off_v) return s >= on_v && s < off_v;
    return s >= on_v || s < off_v;
  endfunction

  task automatic grab_shadow();
    s_pwm = pwm_en; s_flash = flash_en; s_cyc = cycle_sel; s_sw = sw_en;
    s_ext = ext_en; s_duty = duty; s_slope = slope; s_on = on_pt; s_off = off_pt;
  endtask

  task automatic model_step();
    if (!start) begin
      e = 0; fdone = 0;
      for (int c = 0; c < 3; c++) begin lv[c] = 0; cnt[c] = 0; end
      grab_shadow();
    end else begin
      e++;
      if (e % FRAME_CLKS == 0) begin
        int s_now;
        s_now = (fdone / (SLF << s_cyc)) % 16;
        for (int c = 0; c < 3; c++) begin
          int on_v, off_v, d, tgt, span;
          on_v = nib(s_on, c); off_v = nib(s_off, c); d = nib(s_duty, c);
          span = (2 * nib(s_slope, c) + 1) * SFS;
          if (on_v == off_v) begin
            lv[c] = (on_v == 0) ? d : 0; cnt[c] = 0;
          end else begin
            tgt = lit_at(s_now, on_v, off_v) ? d : 0;
            if (lv[c] == tgt) cnt[c] = 0;
            else if (cnt[c] + 1 >= span) begin
              lv[c] += (lv[c] < tgt) ? 1 : -1; cnt[c] = 0;
            end else cnt[c]++;
          end
        end
        fdone++;
        grab_shadow();
      end
    end
  endtask

  function automatic logic [2:0] expect_led();
    logic [2:0] r;
    int t, u, pos, ph;
    r = 3'b000;
    if (!start) return r;
    t = e / TD; u = t % (3 * PH); pos = u % PH; ph = u / PH;
    for (int c = 0; c < 3; c++) begin
      bit o;
      int eff;
      if (!s_pwm) o = s_sw[c];
      else begin
        if (nib(s_on, c) == nib(s_off, c))
          eff = (nib(s_on, c) == 0) ? nib(s_duty, c) : 0;
        else eff = lv[c];
        o = (s_flash || ph == c) && (pos * 15 < eff * PH);
      end
      if (s_ext[c] && !ext_pwm) o = 0;
      r[c] = o;
    end
    return r;
  endfunction

  task automatic check_now(string tag);
    logic [2:0] x;
    x = expect_led();
    checks++;
    if (led !== x) begin
      errors++;
      $display("FAIL %s: led=%b expected=%b at %0t", tag, led, x, $time);
    end
  endtask

  task automatic run(int n, string tag, bit jitter_ext);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_step();
      check_now(tag);
      if (jitter_ext) ext_pwm = $urandom_range(0, 1) == 1;
    end
  endtask

  task automatic restart();
    start = 0; run(3, "R1 idle", 0);
    start = 1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    model_step();
    check_now("R1 reset");

    // normal three-phase, steady brightness, mixed duty codes
    pwm_en = 1; duty = {4'd3, 4'd7, 4'd15};
    restart(); run(400, "R2 R4 normal steady", 0);

    // slope must not matter in steady mode
    slope = 12'hFFF; restart(); run(200, "R4 slope ignored", 0);

    // flash: all colours each phase
    flash_en = 1; slope = 0; restart(); run(400, "R3 flash", 0);
    flash_en = 0;

    // red pinned dark with on = off = 5
    on_pt = 12'h005; off_pt = 12'h005; restart(); run(300, "R5 dark", 0);
    on_pt = 0; off_pt = 0;

    // direct enables
    pwm_en = 0; sw_en = 3'b101; restart(); run(200, "R8 direct", 0);
    ext_en = 3'b100; run(200, "R9 direct gated", 1);

    // external gating in PWM mode
    pwm_en = 1; ext_en = 3'b011; restart(); run(400, "R9 gated", 1);
    ext_en = 0; ext_pwm = 0;

    // stop and restart mid-frame
    run(50, "R2 pre-stop", 0);
    start = 0; run(20, "R1 stopped", 0);
    start = 1; run(200, "R1 restarted", 0);

    // mid-frame duty change waits for the frame end
    run(7, "R10 lead", 0);
    duty = {4'd15, 4'd1, 4'd9};
    run(300, "R10 deferred", 0);

    // directed blink with ramps, including a wrapping window
    duty = {4'd6, 4'd10, 4'd15}; slope = {4'd0, 4'd1, 4'd0};
    on_pt = {4'd12, 4'd4, 4'd2}; off_pt = {4'd3, 4'd9, 4'd10};
    cycle_sel = 0; restart(); run(3000, "R6 R7 blink", 0);
    cycle_sel = 1; restart(); run(5000, "R6 R7 blink long", 0);

    // constrained random configurations
    for (int k = 0; k < 12; k++) begin
      start = 0;
      pwm_en = $urandom_range(0, 7) != 0;
      flash_en = $urandom_range(0, 2) == 0;
      cycle_sel = 2'($urandom_range(0, 1));
      sw_en = 3'($urandom_range(0, 7));
      ext_en = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'b000;
      duty = 12'($urandom_range(0, 4095));
      on_pt = 12'($urandom_range(0, 4095));
      off_pt = 12'($urandom_range(0, 4095));
      slope = 0;
      for (int c = 0; c < 3; c++) slope[4*c +: 4] = 4'($urandom_range(0, 3));
      restart();
      run(2500, "R3 R6 R7 R9 random", ext_en != 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule